// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general purpose I/O port on a simple register bus. Each pin is an output or an input, chosen by one bit of a direction register. The pin data register is not reached at a single address. It sits behind a window of 256 word addresses, and address bits [9:2] of each access act as a pin mask. A write through the window changes only the pins named by the address, so software can set or clear any group of pins with one store and no read-modify-write. A read through the window returns only the masked pins, with every other bit read as zero.

Levels on the external inputs pass through a two-stage synchronizer and are then captured into the data register, but only for pins set as inputs. The output pins show the data register for output pins and a constant high level for input pins. A block of twelve words near the top of the 4 KiB space returns fixed identification bytes. Every other offset reads as zero and ignores writes. Read data is registered. The value appears on the edge that samples the read strobe and stays on the bus until the next read.

Decoding is built around an enumerated address region with four states. `RGN_DATA` covers offsets below 0x400. `RGN_DIR` is offset 0x400 exactly. `RGN_IDENT` covers 0xFD0 to 0xFFF. `RGN_NONE` is every other offset. A unique case over the region steers writes and selects read data. There are no transitions between regions: each access picks its region from its address alone.

Top module: `gpio_maskport`

## Requirements
- R1: After reset the direction register and the data register are 0, every pin output is high, and the read data bus is 0.
- R2: A write to offset 0x400 loads the direction register from write-data bits [7:0]. A read of 0x400 returns it in bits [7:0], with upper bits zero. A direction bit of 1 makes that pin an output.
- R3: A write to an offset below 0x400 updates data bit i from write-data bit i only when address bit i+2 is 1 and direction bit i is 1. All other output-pin data bits keep their value.
- R4: A read from an offset below 0x400 returns the data register ANDed with address bits [9:2] in bits [7:0], and zero in bits [31:8].
- R5: Pin output i equals data bit i when direction bit i is 1, and is 1 when direction bit i is 0.
- R6: A change on an input pin whose direction bit is 0 reaches the data register on the third rising edge after the change. Input levels never change data bits whose direction bit is 1.
- R7: A read of an offset from 0xFD0 to 0xFFF returns, in bits [7:0], entry (offset-0xFD0)>>2 of a 12-entry table, with upper bits zero. The table, from entry 0, is 00 00 00 00 3C 12 07 00 0D F0 05 B1 (hex).
- R8: A read of any other offset returns 0. A write to any other offset changes neither register and no pin output.
- R9: The read data bus takes a new value only on a rising edge where the read strobe is high, one edge after the strobe is presented, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous external input levels |
| pin_out | output | 8 | Pin output levels |

## Verification
A write is due on the first rising edge after it is presented. Register state and pin outputs are therefore sampled on the falling edge that follows that edge. A read result lags its strobe by one edge, so readback is sampled half a cycle after the sampling edge. An input change is due in the data register three edges later and on the read bus four edges later. The latency check holds the read strobe high and samples after every edge, expecting the old value for three samples and the new value on the fourth. The sweeps wait four cycles after each direction change so that the synchronized input bits have settled before the model is compared.

// File: rtl/gpio_maskport_pkg.sv
package gpio_maskport_pkg;

    typedef enum logic [1:0] {
        RGN_DATA,
        RGN_DIR,
        RGN_IDENT,
        RGN_NONE
    } region_e;

    localparam int IDENT_COUNT = 12;
    localparam int IDENT_IDX_W = $clog2(IDENT_COUNT);

    function automatic logic [7:0] ident_byte(input logic [IDENT_IDX_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            4'd4:    b = 8'h3C;
            4'd5:    b = 8'h12;
            4'd6:    b = 8'h07;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] q;
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= '0;
                    else        q <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= '0;
                    else        q <= g_stage[s-1].q;
                end
            end
        end
    endgenerate

    assign sync_out = g_stage[STAGES-1].q;

endmodule

// File: rtl/gpio_pin_core.sv
module gpio_pin_core #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_we,
    input  logic [PINS-1:0] dir_wdata,
    input  logic            data_we,
    input  logic [PINS-1:0] data_wmask,
    input  logic [PINS-1:0] data_wdata,
    input  logic [PINS-1:0] pin_sync,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] data_q,
    output logic [PINS-1:0] pin_out
);

    logic [PINS-1:0] data_nxt;

    // Per-pin next state: output pins take masked writes, input pins track the synchronizer.
    always_comb begin
        for (int i = 0; i < PINS; i++) begin
            if (dir_q[i]) begin
                data_nxt[i] = (data_we && data_wmask[i]) ? data_wdata[i] : data_q[i];
            end else begin
                data_nxt[i] = pin_sync[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
        end else begin
            data_q <= data_nxt;
            if (dir_we) dir_q <= dir_wdata;
        end
    end

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pad
            assign pin_out[p] = dir_q[p] ? data_q[p] : 1'b1;
        end
    endgenerate

    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_we |=> $stable(dir_q));

    assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((data_q ^ $past(data_q)) & $past(dir_q)
                    & ~$past(data_we ? data_wmask : {PINS{1'b0}})) == '0));

    assert_input_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((data_q ^ $past(pin_sync)) & ~$past(dir_q)) == '0));

endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_maskport_pkg::*;
#(
    parameter int                PINS        = 8,
    parameter int                ADDR_W      = 12,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] DIR_OFFSET  = 'h400,
    parameter logic [ADDR_W-1:0] IDENT_BASE  = 'hFD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PINS-1:0]   dir_q,
    input  logic [PINS-1:0]   data_q,
    output logic              dir_we,
    output logic [PINS-1:0]   dir_wdata,
    output logic              data_we,
    output logic [PINS-1:0]   data_wmask,
    output logic [PINS-1:0]   data_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int WINDOW_END = 1 << (PINS + 2);
    localparam int IDENT_END  = int'(IDENT_BASE) + 4 * IDENT_COUNT;

    region_e               region;
    logic [ADDR_W-1:0]     ident_off;
    logic [IDENT_IDX_W-1:0] ident_idx;
    logic [PINS-1:0]       addr_mask;
    logic [DATA_W-1:0]     rd_next;
    logic [DATA_W-1:0]     rdata_q;
    logic                  unused_bits;

    assign addr_mask  = addr[PINS+1:2];
    assign ident_off  = addr - IDENT_BASE;
    assign ident_idx  = ident_off[IDENT_IDX_W+1:2];
    assign unused_bits = ^{ident_off[ADDR_W-1:IDENT_IDX_W+2], ident_off[1:0],
                           wdata[DATA_W-1:PINS]};

    // Region selection from the offset alone.
    always_comb begin
        if (int'(addr) < WINDOW_END) begin
            region = RGN_DATA;
        end else if (addr == DIR_OFFSET) begin
            region = RGN_DIR;
        end else if (int'(addr) >= int'(IDENT_BASE) && int'(addr) < IDENT_END) begin
            region = RGN_IDENT;
        end else begin
            region = RGN_NONE;
        end
    end

    // Write steering and read selection per region.
    always_comb begin
        dir_we     = 1'b0;
        data_we    = 1'b0;
        dir_wdata  = wdata[PINS-1:0];
        data_wdata = wdata[PINS-1:0];
        data_wmask = addr_mask;
        rd_next    = '0;
        unique case (region)
            RGN_DATA: begin
                data_we = wr_en;
                rd_next[PINS-1:0] = data_q & addr_mask;
            end
            RGN_DIR: begin
                dir_we = wr_en;
                rd_next[PINS-1:0] = dir_q;
            end
            RGN_IDENT: begin
                rd_next[7:0] = ident_byte(ident_idx);
            end
            RGN_NONE: begin
                rd_next = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

    assign rdata = rdata_q;

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_q));

    assert_undef_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RGN_NONE) |=> (rdata_q == '0));

    assert_ident_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RGN_IDENT) |=> (rdata_q[DATA_W-1:8] == '0));

    assert_window_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RGN_DATA) |=> (rdata_q[DATA_W-1:PINS] == '0));

endmodule

// File: rtl/gpio_maskport.sv
module gpio_maskport #(
    parameter int PINS        = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out
);

    logic            dir_we;
    logic [PINS-1:0] dir_wdata;
    logic            data_we;
    logic [PINS-1:0] data_wmask;
    logic [PINS-1:0] data_wdata;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] data_q;

    gpio_in_sync #(
        .W      (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_bus_decode #(
        .PINS   (PINS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .dir_q      (dir_q),
        .data_q     (data_q),
        .dir_we     (dir_we),
        .dir_wdata  (dir_wdata),
        .data_we    (data_we),
        .data_wmask (data_wmask),
        .data_wdata (data_wdata),
        .rdata      (bus_rdata)
    );

    gpio_pin_core #(
        .PINS (PINS)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_we     (dir_we),
        .dir_wdata  (dir_wdata),
        .data_we    (data_we),
        .data_wmask (data_wmask),
        .data_wdata (data_wdata),
        .pin_sync   (pin_sync),
        .dir_q      (dir_q),
        .data_q     (data_q),
        .pin_out    (pin_out)
    );

endmodule

// File: tb/gpio_maskport_test.sv
module gpio_maskport_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] id_tab [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h12,
                                8'h07, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always #2.5 clk = ~clk;

    gpio_maskport uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  model;
        logic [7:0]  dirv;

        // R1: reset state
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin_out", {24'h0, pin_out}, 32'h0000_00FF);
        chk("R1 rdata", bus_rdata, 32'h0);
        bus_read(12'h400, rd);
        chk("R1 dir", rd, 32'h0);
        bus_read(12'h3FC, rd);
        chk("R1 data", rd, 32'h0);

        // R2: direction write and readback, upper write bits dropped
        bus_write(12'h400, 32'hFFFF_FF3C);
        bus_read(12'h400, rd);
        chk("R2 dir readback", rd, 32'h0000_003C);
        chk("R5 pin_out after dir", {24'h0, pin_out}, 32'h0000_00C3);

        // R3 R4 R5: sweep directions and every address mask
        model = 8'h00;
        for (int k = 0; k < 16; k++) begin
            logic [7:0] pv;
            dirv = 8'(k * 17);
            pv = 8'h5A ^ 8'(k * 3);
            pin_in = pv;
            bus_write(12'h400, {24'hABCDEF, dirv});
            idle(4);
            model = (model & dirv) | (pv & ~dirv);
            for (int m = 0; m < 256; m++) begin
                logic [7:0] w;
                logic [7:0] rm;
                w = 8'((m * 73) + (k * 29));
                bus_write({2'b00, 8'(m), 2'b00}, {24'hA5C3E1, w});
                model = (model & ~(8'(m) & dirv)) | (w & 8'(m) & dirv);
                chk("R3 R5 pin_out", {24'h0, pin_out}, {24'h0, (model & dirv) | ~dirv});
                rm = 8'(m) ^ 8'hC3;
                bus_read({2'b00, rm, 2'b01}, rd);
                chk("R4 masked read", rd, {24'h0, model & rm});
            end
        end

        // R6: input latency and output pins ignoring inputs
        pin_in = 8'h00;
        bus_write(12'h400, 32'h0F);
        bus_write(12'h3FC, 32'h0A);
        idle(4);
        @(negedge clk);
        bus_addr = 12'h3FC; bus_rd = 1'b1; pin_in = 8'hF5;
        for (int e = 0; e < 4; e++) begin
            @(negedge clk);
            chk("R6 latency", bus_rdata, (e < 3) ? 32'h0A : 32'hFA);
            chk("R6 R5 pin_out", {24'h0, pin_out}, 32'hFA);
        end
        bus_rd = 1'b0;

        // R9: read data holds while no read strobe
        bus_write(12'h400, 32'hFF);
        bus_write(12'h3FC, 32'h00);
        idle(3);
        chk("R9 hold", bus_rdata, 32'hFA);
        chk("R5 all outputs", {24'h0, pin_out}, 32'h00);

        // R7: identification table
        for (int i = 0; i < 12; i++) begin
            bus_read(12'hFD0 + 12'(4 * i), rd);
            chk("R7 ident", rd, {24'h0, id_tab[i]});
        end
        bus_read(12'hFFF, rd);
        chk("R7 ident last byte lane", rd, {24'h0, id_tab[11]});

        // R8: undefined offsets
        bus_write(12'h3FC, 32'h96);
        bus_write(12'h404, 32'hFFFF_FFFF);
        bus_write(12'h401, 32'h0000_0000);
        bus_write(12'h800, 32'h0000_0000);
        bus_write(12'hFCC, 32'h0000_0000);
        chk("R8 pin_out untouched", {24'h0, pin_out}, 32'h96);
        bus_read(12'h400, rd);
        chk("R8 dir untouched", rd, 32'hFF);
        bus_read(12'h3FC, rd);
        chk("R8 data untouched", rd, 32'h96);
        bus_read(12'h404, rd);
        chk("R8 read 404", rd, 32'h0);
        bus_read(12'h800, rd);
        chk("R8 read 800", rd, 32'h0);
        bus_read(12'hFCC, rd);
        chk("R8 read FCC", rd, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule